// File: doc/BRIEF.md
# Write Protect and Busy Controller

This block sits between the serial protocol engine of a small non-volatile word memory and the storage array itself. The engine hands it single-cycle events: set the write-enable latch, clear it, read a word, or write a word (address plus 16-bit data). The controller decides whether a write may go ahead, runs a self-timed programming interval counted in system clocks, and places the word into the array only when that interval ends.

Two independent gates protect the array. One is a software enable latch that comes up cleared, is set by an enable event and is cleared by a disable event. The other is a hardware protect pin. While the pin is high, new writes are refused. If the pin rises during a programming interval, the interval is cut short and the addressed word is left holding a defined corrupt pattern (all ones). During the interval the block reports busy both as a flag to the engine and on an active-low ready pin, and it ignores every other event.

Top module: `wp_busy_ctrl`

## Requirements
- R1: After reset the enable latch is 0, busy_o is 0, rdy_pin_o is 1 and rd_valid_o is 0.
- R2: When idle, a wen_cmd pulse sets wel_o and a wds_cmd pulse clears it on the next cycle. If both arrive in the same cycle, the latch is cleared.
- R3: When idle, a rd_cmd pulse gives rd_valid_o high for one cycle, on the cycle after, with the stored word at rd_addr on rd_data_o. This holds whatever the values of wel_o and prot_pin, and the read leaves wel_o unchanged.
- R4: A wr_cmd is accepted only when idle, with wel_o = 1 and prot_pin = 0. Otherwise it is ignored: busy_o stays 0 and the stored word is unchanged.
- R5: After an accepted write, busy_o is 1 for exactly PROG_CYCLES consecutive cycles, starting on the cycle after the wr_cmd.
- R6: The written word becomes visible to reads only when the programming interval completes.
- R7: While busy_o is 1, wen_cmd, wds_cmd, rd_cmd and wr_cmd have no effect: wel_o does not change, no rd_valid_o is produced, and no new interval starts.
- R8: If prot_pin is high on a busy cycle, busy_o drops on the next cycle and the addressed word holds all ones.
- R9: wen_cmd, wds_cmd and rd_cmd behave the same with prot_pin high as with it low.
- R10: Completing a write does not clear wel_o, so further writes need no new enable event.
- R11: rdy_pin_o is always the inverse of busy_o. It is low exactly while programming runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| prot_pin | input | 1 | Hardware protect level; high blocks and aborts writes |
| wen_cmd | input | 1 | Pulse: set write-enable latch |
| wds_cmd | input | 1 | Pulse: clear write-enable latch |
| rd_cmd | input | 1 | Pulse: read one word |
| rd_addr | input | ADDR_W | Read address |
| wr_cmd | input | 1 | Pulse: write one word |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wel_o | output | 1 | Write-enable latch state |
| busy_o | output | 1 | Programming in progress |
| rdy_pin_o | output | 1 | Active-low ready/busy pin (0 = busy) |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DATA_W | Read data |

## Verification
The bench counts the exact number of busy cycles per write. A timer that is off by one shows up as a count of PROG_CYCLES plus or minus one. It injects enable, disable, read and write events in the middle of a programming interval. A design that let them through would clear the latch, emit a stray read result, or restart the timer. It raises the protect pin partway through an interval and expects busy to fall at once and the word to read back as all ones. A design that ignored the abort would instead run to completion and store the requested data. It also drives enable and disable together, and toggles the latch with the protect pin high, to catch wrong priority and over-eager gating of the pin.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  typedef enum logic [1:0] {
    COMMIT_NONE  = 2'd0,
    COMMIT_WORD  = 2'd1,
    COMMIT_SCRAP = 2'd2
  } commit_e;
endpackage

// File: rtl/wpb_enable_latch.sv
module wpb_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/wpb_prog_timer.sv
module wpb_prog_timer #(
  parameter int PROG_CYCLES = 500000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             abort_i,
  output logic             busy_o,
  output logic             rdy_o,
  output wpb_pkg::commit_e commit_o
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             last_w;

  assign last_w = (cnt_q == CNT_W'(1));

  always_comb begin
    if (!busy_o)      commit_o = wpb_pkg::COMMIT_NONE;
    else if (abort_i) commit_o = wpb_pkg::COMMIT_SCRAP;
    else if (last_w)  commit_o = wpb_pkg::COMMIT_WORD;
    else              commit_o = wpb_pkg::COMMIT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      rdy_o  <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (abort_i || last_w) begin
        busy_o <= 1'b0;
        rdy_o  <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end else if (start_i) begin
      busy_o <= 1'b1;
      rdy_o  <= 1'b0;
      cnt_q  <= CNT_W'(PROG_CYCLES);
    end
  end

  // R5
  cnt_live_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cnt_q != '0));

  // R8
  abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && abort_i) |=> !busy_o);

  // R11
  rdy_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_o == !busy_o);
endmodule

// File: rtl/wpb_word_store.sv
module wpb_word_store #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid_o <= 1'b0;
    else     rvalid_o <= re_i;
  end

  // R3
  rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> $past(re_i));
endmodule

// File: rtl/wp_busy_ctrl.sv
module wp_busy_ctrl #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_pin,
  input  logic              wen_cmd,
  input  logic              wds_cmd,
  input  logic              rd_cmd,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_cmd,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wel_o,
  output logic              busy_o,
  output logic              rdy_pin_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [DATA_W-1:0] SCRAP_WORD = {DATA_W{1'b1}};

  logic              idle_w;
  logic              start_w;
  logic              re_w;
  logic              we_w;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] commit_data_w;
  wpb_pkg::commit_e  commit_w;

  assign idle_w  = !busy_o;
  assign start_w = idle_w && wr_cmd && wel_o && !prot_pin;
  assign re_w    = idle_w && rd_cmd;
  assign we_w    = (commit_w != wpb_pkg::COMMIT_NONE);
  assign commit_data_w = (commit_w == wpb_pkg::COMMIT_SCRAP) ? SCRAP_WORD : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (start_w) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  wpb_enable_latch u_latch (
    .clk   (clk),
    .rst   (rst),
    .set_i (idle_w && wen_cmd),
    .clr_i (idle_w && wds_cmd),
    .q_o   (wel_o)
  );

  wpb_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_w),
    .abort_i  (prot_pin),
    .busy_o   (busy_o),
    .rdy_o    (rdy_pin_o),
    .commit_o (commit_w)
  );

  wpb_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .we_i     (we_w),
    .waddr_i  (addr_q),
    .wdata_i  (commit_data_w),
    .re_i     (re_w),
    .raddr_i  (rd_addr),
    .rdata_o  (rd_data_o),
    .rvalid_o (rd_valid_o)
  );

  // R4
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(wr_cmd && wel_o && !prot_pin));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(wel_o));

  // R7
  read_block_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_cmd && !busy_o));
endmodule

// File: tb/wp_busy_ctrl_tb.sv
module wp_busy_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int AW     = 7;
  localparam int DW     = 16;
  localparam int PROG   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prot_pin = 1'b0;
  logic wen_cmd = 1'b0, wds_cmd = 1'b0, rd_cmd = 1'b0, wr_cmd = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wel_o, busy_o, rdy_pin_o, rd_valid_o;
  logic [DW-1:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  int busy_run = 0;
  logic [DW-1:0] model [1 << AW];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #(CLK_P/2) clk = ~clk;

  wp_busy_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst(rst), .prot_pin(prot_pin),
    .wen_cmd(wen_cmd), .wds_cmd(wds_cmd),
    .rd_cmd(rd_cmd), .rd_addr(rd_addr),
    .wr_cmd(wr_cmd), .wr_addr(wr_addr), .wr_data(wr_data),
    .wel_o(wel_o), .busy_o(busy_o), .rdy_pin_o(rdy_pin_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: ready pin relation and scoreboard of read results
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_o) busy_run++;
      chk(rdy_pin_o == !busy_o, "R11", int'(rdy_pin_o), int'(!busy_o));
      if (rd_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected read", int'(rd_data_o), 0);
        end else begin
          automatic logic [DW-1:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(rd_data_o == e, t, int'(rd_data_o), int'(e));
        end
      end
    end
  end

  task automatic do_wen();
    @(negedge clk) wen_cmd = 1'b1;
    @(negedge clk) wen_cmd = 1'b0;
  endtask

  task automatic do_wds();
    @(negedge clk) wds_cmd = 1'b1;
    @(negedge clk) wds_cmd = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit expect_out, input string req);
    @(negedge clk);
    rd_cmd = 1'b1; rd_addr = a;
    if (expect_out) begin
      exp_q.push_back(model[a]);
      tag_q.push_back(req);
    end
    @(negedge clk) rd_cmd = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_cmd = 1'b1; wr_addr = a; wr_data = d;
    busy_run = 0;
    @(negedge clk) wr_cmd = 1'b0;
  endtask

  task automatic wait_idle(input int exp_cycles, input string req);
    while (busy_o) @(negedge clk);
    chk(busy_run == exp_cycles, req, busy_run, exp_cycles);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(wel_o == 1'b0, "R1 wel", int'(wel_o), 0);
    chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
    chk(rdy_pin_o == 1'b1, "R1 rdy", int'(rdy_pin_o), 1);
    chk(rd_valid_o == 1'b0, "R1 rvalid", int'(rd_valid_o), 0);

    // R2 enable
    do_wen();
    chk(wel_o == 1'b1, "R2 set", int'(wel_o), 1);

    // R5 / R6 normal write
    start_write(7'h05, 16'hA5C3);
    wait_idle(PROG, "R5 busy length");
    model[5] = 16'hA5C3;
    do_read(7'h05, 1'b1, "R6 committed word");

    // R2 disable, R4 write refused by latch
    do_wds();
    chk(wel_o == 1'b0, "R2 clear", int'(wel_o), 0);
    start_write(7'h05, 16'h1111);
    wait_idle(0, "R4 latch gate");
    do_read(7'h05, 1'b1, "R4 word kept (latch)");

    // R4 write refused by pin, R9 pin-independent events
    do_wen();
    prot_pin = 1'b1;
    start_write(7'h05, 16'h2222);
    wait_idle(0, "R4 pin gate");
    do_read(7'h05, 1'b1, "R9 read with pin high");
    do_wds();
    chk(wel_o == 1'b0, "R9 clear with pin", int'(wel_o), 0);
    do_wen();
    chk(wel_o == 1'b1, "R9 set with pin", int'(wel_o), 1);
    @(negedge clk) prot_pin = 1'b0;

    // R7 events ignored while busy
    start_write(7'h7F, 16'h3C3C);
    do_wds();
    do_read(7'h00, 1'b0, "R7");
    @(negedge clk);
    wr_cmd = 1'b1; wr_addr = 7'h7F; wr_data = 16'h0000;
    @(negedge clk) wr_cmd = 1'b0;
    wait_idle(PROG, "R7 no restart");
    chk(wel_o == 1'b1, "R7 latch held", int'(wel_o), 1);
    model[7'h7F] = 16'h3C3C;
    do_read(7'h7F, 1'b1, "R7 word from first write");

    // R10 latch survives completion
    start_write(7'h00, 16'h0F0F);
    wait_idle(PROG, "R10 second write accepted");
    model[0] = 16'h0F0F;
    do_read(7'h00, 1'b1, "R10 second word");

    // R2 simultaneous set and clear
    @(negedge clk); wen_cmd = 1'b1; wds_cmd = 1'b1;
    @(negedge clk); wen_cmd = 1'b0; wds_cmd = 1'b0;
    chk(wel_o == 1'b0, "R2 clear wins", int'(wel_o), 0);

    // R8 abort
    do_wen();
    start_write(7'h09, 16'h1234);
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b1, "R8 busy before abort", int'(busy_o), 1);
    prot_pin = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R8 busy dropped", int'(busy_o), 0);
    prot_pin = 1'b0;
    model[9] = 16'hFFFF;
    do_read(7'h09, 1'b1, "R8 scrap word");

    // R3 read with latch clear, latch untouched
    do_wds();
    do_read(7'h00, 1'b1, "R3 read with latch clear");
    chk(wel_o == 1'b0, "R3 latch unchanged", int'(wel_o), 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule